// File: doc/BRIEF.md
# EEPROM Page Write Load Controller

This block is the write-capture front end of a byte-wide parallel nonvolatile memory. It runs on a system clock. The active-low chip-select, write-strobe and output-enable pins are sampled with that clock, and the block finds the moments when a host write opens and closes. It latches the byte address when a write opens and the byte data when it closes. The bytes are gathered into a 64-slot buffer for a single page.

Every accepted byte load restarts a window counter, whose length is a parameter in system clock cycles. A load is accepted only if its page number matches the first load of the page. When the window runs out with no load in progress, the block raises a one-cycle program-start pulse. It then holds the page number, the byte-valid mask and the buffered data steady for the programming engine. An external timer drives a busy input for the length of the programming cycle. When busy drops, the mask is cleared and the block waits for a new page.

Top module: `page_load_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the byte-valid mask is all zero, the program-start pulse is low and the page address output is zero.
- R2: A write qualifies only while chip-select and write-strobe are both low and output-enable is high. Strobes with output-enable low never load a byte.
- R3: The address is taken in the cycle where the later of the two strobe falling edges is sampled. Address changes after that point have no effect on the load.
- R4: The data is taken in the cycle where the earlier of the two strobe rising edges is sampled. If output-enable falls while both strobes are still low, the load is dropped.
- R5: Address bits 5..0 select the buffer slot: mask bit i and page data bits 8*i+7..8*i. Address bits 14..6 are the page address.
- R6: A load whose page address differs from the first load of the open page is ignored. It does not set a mask bit and does not restart the window.
- R7: Each accepted load restarts a window of WINDOW_CYCLES cycles. When the window expires with no load in progress and at least one valid byte, a single-cycle program-start pulse is raised. The mask and page address stay unchanged after the pulse.
- R8: Any number of loads may be collected while each one falls within the window. Writing the same slot again keeps the last data, and all 64 slots can be filled.
- R9: After program start, write strobes are ignored. The mask is cleared once the busy input has risen and then fallen.
- R10: If the window expires with an empty mask (all loads were dropped), the block returns to idle and raises no program-start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip-select strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 15 | Byte address |
| data_i | input | 8 | Write data |
| busy_i | input | 1 | High while the programming timer runs |
| page_addr_o | output | 9 | Page address of the buffered page |
| byte_valid_o | output | 64 | One bit per loaded slot |
| page_data_o | output | 512 | Buffered bytes, slot i at bits 8*i+7..8*i |
| prog_start_o | output | 1 | One-cycle pulse that starts programming |

## Verification
The assertions check several properties on every cycle. The program-start pulse lasts one cycle and never fires with an empty mask. The mask and page address are frozen in the cycle after the pulse. The mask gains at most one bit per cycle, and the page address changes only while the mask is empty. The behaviours tied to the strobe order can only be shown by the bench scenarios, because they depend on the input history:

- which edge latches the address and which edge latches the data;
- a dropped load when output-enable falls during a write;
- a foreign-page load being ignored without extending the window;
- strobes being ignored while busy;
- the exact cycle at which the window expires.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LAUNCH,
    ST_PROG
  } plc_state_e;
endpackage

// File: rtl/plc_strobe_sync.sv
module plc_strobe_sync #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          open_o,
  output logic          close_o,
  output logic          abort_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic s_ce, s_we, s_oe, act_prev, act_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_ce     <= 1'b1;
      s_we     <= 1'b1;
      s_oe     <= 1'b1;
      addr_o   <= '0;
      data_o   <= '0;
      act_prev <= 1'b0;
    end else begin
      s_ce     <= ce_ni;
      s_we     <= we_ni;
      s_oe     <= oe_ni;
      addr_o   <= addr_i;
      data_o   <= data_i;
      act_prev <= act_now;
    end
  end

  assign act_now = !s_ce && !s_we && s_oe;
  // open: later falling strobe; close: earlier rising strobe; abort: oe dropped
  assign open_o  = act_now && !act_prev;
  assign close_o = !act_now && act_prev && (s_ce || s_we);
  assign abort_o = !act_now && act_prev && !(s_ce || s_we);
endmodule

// File: rtl/plc_window_timer.sv
module plc_window_timer #(
  parameter int WINDOW_CYCLES = 18750
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  input  logic hold_i,
  output logic expired_o
);
  localparam int CW = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (restart_i)             cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && !hold_i && (cnt_q == LAST);
endmodule

// File: rtl/plc_page_buffer.sv
module plc_page_buffer #(
  parameter int DW    = 8,
  parameter int SLOTS = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [$clog2(SLOTS)-1:0] idx_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic                     clr_i,
  output logic [SLOTS-1:0]         mask_o,
  output logic [SLOTS*DW-1:0]      data_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic          hit;
    logic [DW-1:0] byte_q;
    logic          vld_q;

    assign hit = wr_i && (idx_i == g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        if (clr_i)    vld_q <= 1'b0;
        else if (hit) vld_q <= 1'b1;
        if (hit)      byte_q <= wdata_i;
      end
    end

    assign mask_o[g]              = vld_q;
    assign data_o[g*DW +: DW]     = byte_q;
  end
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl #(
  parameter int AW            = 15,
  parameter int DW            = 8,
  parameter int SLOTS         = 64,
  parameter int WINDOW_CYCLES = 18750
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ce_ni,
  input  logic                          we_ni,
  input  logic                          oe_ni,
  input  logic [AW-1:0]                 addr_i,
  input  logic [DW-1:0]                 data_i,
  input  logic                          busy_i,
  output logic [AW-$clog2(SLOTS)-1:0]   page_addr_o,
  output logic [SLOTS-1:0]              byte_valid_o,
  output logic [SLOTS*DW-1:0]           page_data_o,
  output logic                          prog_start_o
);
  import plc_pkg::*;

  localparam int IW = $clog2(SLOTS);
  localparam int PW = AW - IW;

  plc_state_e    state_q;
  logic          w_open, w_close, w_abort;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_data;
  logic [IW-1:0] idx_q;
  logic [PW-1:0] page_q;
  logic          pend_q, start_q;
  logic          in_idle, in_load, take, expired, buf_wr, buf_clr;

  plc_strobe_sync #(.AW(AW), .DW(DW)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_ni  (ce_ni),
    .we_ni  (we_ni),
    .oe_ni  (oe_ni),
    .addr_i (addr_i),
    .data_i (data_i),
    .open_o (w_open),
    .close_o(w_close),
    .abort_o(w_abort),
    .addr_o (s_addr),
    .data_o (s_data)
  );

  assign in_idle = (state_q == ST_IDLE);
  assign in_load = (state_q == ST_LOAD);
  assign take    = w_open && (in_idle || (in_load && s_addr[AW-1:IW] == page_q));
  assign buf_wr  = in_load && pend_q && w_close;
  assign buf_clr = (state_q == ST_PROG) && !busy_i;

  plc_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(take),
    .run_i    (in_load),
    .hold_i   (pend_q),
    .expired_o(expired)
  );

  plc_page_buffer #(.DW(DW), .SLOTS(SLOTS)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (buf_wr),
    .idx_i  (idx_q),
    .wdata_i(s_data),
    .clr_i  (buf_clr),
    .mask_o (byte_valid_o),
    .data_o (page_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      idx_q   <= '0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (take) begin
        page_q <= s_addr[AW-1:IW];
        idx_q  <= s_addr[IW-1:0];
        pend_q <= 1'b1;
      end else if (in_load && pend_q && (w_close || w_abort)) begin
        pend_q <= 1'b0;
      end
      unique case (state_q)
        ST_IDLE:   if (take) state_q <= ST_LOAD;
        ST_LOAD: begin
          if (!take && expired) begin
            if (|byte_valid_o) begin
              start_q <= 1'b1;
              state_q <= ST_LAUNCH;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_LAUNCH: if (busy_i) state_q <= ST_PROG;
        ST_PROG:   if (!busy_i) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign page_addr_o  = page_q;
  assign prog_start_o = start_q;
endmodule

// File: rtl/page_load_ctrl_checker.sv
module page_load_ctrl_checker #(
  parameter int PW    = 9,
  parameter int SLOTS = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             prog_start_o,
  input logic [SLOTS-1:0] byte_valid_o,
  input logic [PW-1:0]    page_addr_o
);
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |=> !prog_start_o);

  a_r7_start_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> (byte_valid_o != '0));

  a_r7_frozen_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |=> ($stable(byte_valid_o) && $stable(page_addr_o)));

  a_r8_one_slot_per_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(byte_valid_o & ~$past(byte_valid_o)) <= 1);

  a_r6_page_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_addr_o != $past(page_addr_o)) |-> ($past(byte_valid_o) == '0));
endmodule

bind page_load_ctrl page_load_ctrl_checker #(
  .PW   (AW - $clog2(SLOTS)),
  .SLOTS(SLOTS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .prog_start_o(prog_start_o),
  .byte_valid_o(byte_valid_o),
  .page_addr_o (page_addr_o)
);

// File: tb/page_load_ctrl_test.sv
`timescale 1ns/1ps
module page_load_ctrl_test;
  localparam int WIN = 20;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         ce_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1;
  logic [14:0]  addr_i = '0;
  logic [7:0]   data_i = '0;
  logic         busy_i = 1'b0;
  logic [8:0]   page_addr_o;
  logic [63:0]  byte_valid_o;
  logic [511:0] page_data_o;
  logic         prog_start_o;

  int checks = 0, errors = 0, pulses = 0, busy_cnt = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  page_load_ctrl #(.WINDOW_CYCLES(WIN)) uut (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .addr_i, .data_i, .busy_i,
    .page_addr_o, .byte_valid_o, .page_data_o, .prog_start_o
  );

  // behavioural reference model
  int         m_state, m_cnt, m_idx, m_page;
  bit         m_pend, m_start, m_act, m_ce, m_we, m_oe;
  int         m_addr, m_data;
  logic [63:0] m_mask;
  logic [7:0]  m_mem [64];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_state = 0; m_cnt = 0; m_idx = 0; m_page = 0; m_pend = 0; m_start = 0;
      m_act = 0; m_ce = 1; m_we = 1; m_oe = 1; m_addr = 0; m_data = 0; m_mask = '0;
      foreach (m_mem[i]) m_mem[i] = 8'h00;
    end else begin
      bit act, op, cl, ab, tk;
      act = !m_ce && !m_we && m_oe;
      op = act && !m_act;
      cl = !act && m_act && (m_ce || m_we);
      ab = !act && m_act && !(m_ce || m_we);
      m_start = 0;
      case (m_state)
        0: if (op) begin
             m_page = m_addr / 64; m_idx = m_addr % 64; m_pend = 1; m_cnt = 0; m_state = 1;
           end
        1: begin
             tk = op && (m_addr / 64 == m_page);
             if (tk) begin
               m_idx = m_addr % 64; m_pend = 1; m_cnt = 0;
             end else begin
               if (m_pend && cl) begin
                 m_mask[m_idx] = 1'b1; m_mem[m_idx] = m_data[7:0]; m_pend = 0;
               end else if (m_pend && ab) m_pend = 0;
               else if (!m_pend && m_cnt == WIN - 1) begin
                 if (m_mask != 0) begin m_start = 1; m_state = 2; end
                 else m_state = 0;
               end
               if (m_cnt != WIN - 1) m_cnt++;
             end
           end
        2: if (busy_i) m_state = 3;
        default: if (!busy_i) begin m_mask = '0; m_state = 0; end
      endcase
      m_act = act; m_ce = ce_ni; m_we = we_ni; m_oe = oe_ni;
      m_addr = int'(addr_i); m_data = int'(data_i);
    end
  end

  function automatic logic [511:0] model_data();
    logic [511:0] v;
    for (int i = 0; i < 64; i++) v[8*i +: 8] = m_mem[i];
    return v;
  endfunction

  // per-cycle comparison, busy timer and pulse counter
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      checks++;
      if (page_addr_o !== 9'(m_page) || byte_valid_o !== m_mask ||
          page_data_o !== model_data() || prog_start_o !== m_start) begin
        errors++;
        $display("FAIL cycle model R5/R7 at %0t: page %0h/%0h mask %h/%h start %0b/%0b data_eq %0b",
                 $time, page_addr_o, m_page, byte_valid_o, m_mask, prog_start_o, m_start,
                 page_data_o === model_data());
      end
      if (prog_start_o) begin pulses++; busy_i = 1'b1; busy_cnt = 12; end
      else if (busy_cnt > 0) begin busy_cnt--; if (busy_cnt == 0) busy_i = 1'b0; end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // write-strobe controlled: write strobe falls last and rises first
  task automatic wr_we(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; data_i = d; oe_ni = 1'b1; ce_ni = 1'b0;
    @(negedge clk_i); we_ni = 1'b0;
    @(negedge clk_i); addr_i = '1;
    @(negedge clk_i); we_ni = 1'b1;
    @(negedge clk_i); ce_ni = 1'b1; data_i = ~d;
  endtask

  // chip-select controlled: chip-select falls last and rises first
  task automatic wr_ce(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = 15'h0; data_i = 8'h00; we_ni = 1'b0;
    @(negedge clk_i); addr_i = a; ce_ni = 1'b0;
    @(negedge clk_i); addr_i = 15'h7fc0;
    @(negedge clk_i); data_i = d; ce_ni = 1'b1;
    @(negedge clk_i); we_ni = 1'b1; data_i = 8'h00;
  endtask

  task automatic wait_quiet();
    idle(WIN + 25);
  endtask

  initial begin
    int p0;
    idle(3);
    chk("R1 reset mask", byte_valid_o, 64'h0);
    chk("R1 reset start", 64'(prog_start_o), 64'h0);
    chk("R1 reset page", 64'(page_addr_o), 64'h0);
    rst_ni = 1'b1;
    idle(2);
    chk("R1 after reset mask", byte_valid_o, 64'h0);

    // R2: output enable low blocks loads
    @(negedge clk_i); oe_ni = 1'b0; addr_i = 15'h0041; data_i = 8'h77; ce_ni = 1'b0; we_ni = 1'b0;
    idle(3); we_ni = 1'b1; ce_ni = 1'b1; oe_ni = 1'b1;
    idle(3);
    chk("R2 oe low no load", byte_valid_o, 64'h0);
    wait_quiet();

    // R3 R4 R5 R7: three loads on page 5
    p0 = pulses;
    wr_we(15'h0140, 8'ha5);
    wr_we(15'h017f, 8'h3c);
    wr_ce(15'h014a, 8'hff);
    idle(1);
    chk("R5 mask slots 0,10,63", byte_valid_o, 64'h8000_0000_0000_0401);
    chk("R5 page address", 64'(page_addr_o), 64'h5);
    chk("R4 slot 0 data", 64'(page_data_o[7:0]), 64'ha5);
    chk("R4 slot 63 data", 64'(page_data_o[511:504]), 64'h3c);
    chk("R3 ce-controlled slot 10", 64'(page_data_o[87:80]), 64'hff);
    chk("R7 no start inside window", 64'(pulses - p0), 64'h0);
    idle(WIN + 2);
    chk("R7 one start pulse", 64'(pulses - p0), 64'h1);
    chk("R7 mask held after start", byte_valid_o, 64'h8000_0000_0000_0401);
    // R9: strobes ignored while programming
    wr_we(15'h0150, 8'h11);
    wait_quiet();
    chk("R9 mask cleared after busy", byte_valid_o, 64'h0);
    chk("R9 busy write not loaded", 64'(pulses - p0), 64'h1);

    // R6: foreign page ignored
    p0 = pulses;
    wr_we(15'h01c1, 8'h21);
    wr_we(15'h0202, 8'h22);
    idle(1);
    chk("R6 foreign page ignored", byte_valid_o, 64'h2);
    chk("R6 page kept", 64'(page_addr_o), 64'h7);
    wait_quiet();
    chk("R6 single start", 64'(pulses - p0), 64'h1);
    wait_quiet();

    // R4 R10: abort via output enable, empty page closes silently
    p0 = pulses;
    @(negedge clk_i); addr_i = 15'h0003; data_i = 8'h55; ce_ni = 1'b0;
    @(negedge clk_i); we_ni = 1'b0;
    idle(2); oe_ni = 1'b0;
    @(negedge clk_i); we_ni = 1'b1; ce_ni = 1'b1;
    @(negedge clk_i); oe_ni = 1'b1;
    idle(2);
    chk("R4 aborted load", byte_valid_o, 64'h0);
    wait_quiet();
    chk("R10 no start on empty page", 64'(pulses - p0), 64'h0);

    // R8: rewrite and full page
    p0 = pulses;
    wr_we(15'h0304, 8'h11);
    wr_we(15'h0304, 8'h22);
    idle(1);
    chk("R8 last data kept", 64'(page_data_o[39:32]), 64'h22);
    for (int i = 0; i < 64; i++) wr_we(15'h0300 + 15'(i), 8'(i * 3 + 1));
    idle(1);
    chk("R8 all slots valid", byte_valid_o, '1);
    chk("R8 slot 4 overwritten", 64'(page_data_o[39:32]), 64'hd);
    chk("R8 no start during long load", 64'(pulses - p0), 64'h0);
    wait_quiet();
    chk("R8 one start for full page", 64'(pulses - p0), 64'h1);
    wait_quiet();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    done = 1;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule